// File: doc/BRIEF.md
# Serial Panel Register-Write Controller

This block sets up a small display panel over a four-wire serial link. The host hands it one request at a time: power up, power down, set contrast, set invert, set flip or run the full init sequence. The controller turns each request into one or more 32-bit register-write frames. Around the display-on and display-off writes it also drives the panel's supply-enable and panel-enable pins, always in the same order.

The host side is a valid/ready request port. The controller takes a request on a rising clock edge where both `req_valid` and `req_ready` are high. A host that is held off keeps `req_valid`, `req_op` and `req_arg` steady until that edge. `req_ready` is the inverse of `busy`, so back-pressure lasts for the whole of an operation. The panel side is a write-only serial master with three outputs: clock, data and select.

Top module: `panel_cfg_ctrl`

## Requirements
- R1: Each register write is one 32-bit frame, sent MSB first: bits 31..24 are 0x00, bits 23..16 are the register address, bits 15..8 are 0x01 and bits 7..0 are the value.
- R2: `spi_ss` is active high and stays high for all 32 bits of a frame. Between two frames it stays low for at least 32 system clocks, which is two serial clock periods.
- R3: `spi_sclk` runs at the system clock divided by 16 and idles high whenever `spi_ss` is low. `spi_mosi` changes on the falling edge and holds steady across the rising edge, where the panel samples it. Every frame has exactly 32 rising edges.
- R4: Contrast (`req_op`=2) writes register 0x0B with the 6-bit value `req_arg` (0 to 63).
- R5: Flip (`req_op`=4) writes register 0x06. The value is 0x02 when `req_arg[0]`=1 (upside down) and 0x04 when `req_arg[0]`=0 (normal).
- R6: Invert (`req_op`=3) writes register 0x27. The value is 0x10 when `req_arg[0]`=1 and 0x00 when `req_arg[0]`=0.
- R7: Power up (`req_op`=0) runs these steps in order: `supply_en` rises one clock after acceptance, `panel_en` rises one clock later, the serial interface is enabled, and then the frame 0x00040101 (display on) is sent.
- R8: Power down (`req_op`=1) sends the frame 0x00040100 (display off), disables the interface, then lowers `panel_en` and then `supply_en`. `panel_en` is never high while `supply_en` is low. A power down while the display is off is ignored.
- R9: Contrast, invert and flip requests that arrive while the display is off are accepted and then dropped. They send no frame, and `busy` stays low.
- R10: Init (`req_op`=5) first runs the power-up pin steps. It then sends 25 fixed frames. These include contrast 0x2F (the reset default of 47) on register 0x0B and normal orientation 0x04 on register 0x06. The last frame is the display-on frame 0x00040101, and the display then counts as on.
- R11: `req_ready` equals `!busy`. `busy` rises in the cycle after an operation is accepted and stays high until that operation finishes: for a frame-ending operation, in the same cycle that `spi_ss` falls after its last frame; for power down, after `supply_en` falls. Op codes 6 and 7, and any dropped request, leave `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (not busy) |
| req_op | input | 3 | Request code: 0 up, 1 down, 2 contrast, 3 invert, 4 flip, 5 init |
| req_arg | input | 6 | Contrast value, or bit 0 as invert/flip enable |
| busy | output | 1 | Operation in progress |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data out |
| spi_ss | output | 1 | Slave select, active high |
| supply_en | output | 1 | Panel supply enable |
| panel_en | output | 1 | Panel enable |

## Verification
The end of an operation and the arrival of the next request can land in the same cycle. The cycle in which `spi_ss` falls is also the cycle in which `busy` drops, and a request held waiting is taken on the very next edge. The bench provokes this by raising `req_valid` while a frame is still being sent and holding it there. A scoreboard then checks that the next frame arrives intact and that the select-low gap before it still lasts at least two serial clock periods.

// File: rtl/panel_cfg_pkg.sv
package panel_cfg_pkg;

  typedef enum logic [2:0] {
    OP_PWR_UP   = 3'd0,
    OP_PWR_DN   = 3'd1,
    OP_CONTRAST = 3'd2,
    OP_INVERT   = 3'd3,
    OP_FLIP     = 3'd4,
    OP_INIT     = 3'd5
  } op_e;

  localparam logic [7:0] REG_CONTRAST = 8'h0B;
  localparam logic [7:0] REG_ORIENT   = 8'h06;
  localparam logic [7:0] REG_INVERT   = 8'h27;
  localparam logic [7:0] REG_DISPLAY  = 8'h04;
  localparam int         INIT_LEN     = 25;

  // Register/value pair for one step of the power-on programming list.
  function automatic logic [15:0] init_entry(input logic [4:0] i,
                                             input logic [5:0] contrast);
    case (i)
      5'd0:  init_entry = 16'h0f01;
      5'd1:  init_entry = 16'h0906;
      5'd2:  init_entry = 16'h16a6;
      5'd3:  init_entry = 16'h1e49;
      5'd4:  init_entry = 16'h1f26;
      5'd5:  init_entry = {REG_CONTRAST, 2'b00, contrast};
      5'd6:  init_entry = 16'h0c2b;
      5'd7:  init_entry = 16'h195e;
      5'd8:  init_entry = 16'h1a15;
      5'd9:  init_entry = 16'h1b15;
      5'd10: init_entry = 16'h1d01;
      5'd11: init_entry = 16'h0003;
      5'd12: init_entry = 16'h0110;
      5'd13: init_entry = 16'h020a;
      5'd14: init_entry = {REG_ORIENT, 8'h04};
      5'd15: init_entry = 16'h082e;
      5'd16: init_entry = 16'h2412;
      5'd17: init_entry = 16'h253f;
      5'd18: init_entry = 16'h260b;
      5'd19: init_entry = 16'h2700;
      5'd20: init_entry = 16'h2800;
      5'd21: init_entry = 16'h29f6;
      5'd22: init_entry = 16'h2a03;
      5'd23: init_entry = 16'h2b0a;
      default: init_entry = {REG_DISPLAY, 8'h01};
    endcase
  endfunction

  function automatic logic [31:0] make_frame(input logic [7:0] addr,
                                             input logic [7:0] val);
    make_frame = {8'h00, addr, 8'h01, val};
  endfunction

endpackage

// File: rtl/panel_spi_tx.sv
module panel_spi_tx #(
  parameter int DIV       = 16,
  parameter int FRAME_W   = 32,
  parameter int GAP_SCLKS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  output logic               tx_ready,
  output logic               tx_done,
  output logic               sclk,
  output logic               mosi,
  output logic               ss
);
  localparam int CW       = $clog2(DIV);
  localparam int BW       = $clog2(FRAME_W + 1);
  localparam int GAP_CLKS = GAP_SCLKS * DIV;
  localparam int GW       = $clog2(GAP_CLKS + 1);
  localparam logic [CW-1:0] HALF_L = CW'(DIV / 2 - 1);
  localparam logic [CW-1:0] LAST_L = CW'(DIV - 1);
  localparam logic [BW-1:0] NBIT_L = BW'(FRAME_W);
  localparam logic [GW-1:0] GAP_L  = GW'(GAP_CLKS - 1);

  typedef enum logic [1:0] {T_IDLE, T_SHIFT, T_GAP} tst_e;
  tst_e               st;
  logic [CW-1:0]      cnt;
  logic [BW-1:0]      bits;
  logic [GW-1:0]      gap;
  logic [FRAME_W-1:0] shreg;

  assign tx_ready = (st == T_IDLE);
  assign tx_done  = (st == T_SHIFT) && (bits == NBIT_L) && (cnt == HALF_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= T_IDLE;
      cnt   <= '0;
      bits  <= '0;
      gap   <= '0;
      shreg <= '0;
      sclk  <= 1'b1;
      mosi  <= 1'b0;
      ss    <= 1'b0;
    end else begin
      case (st)
        T_IDLE: if (start) begin
          shreg <= frame;
          ss    <= 1'b1;
          cnt   <= '0;
          bits  <= '0;
          st    <= T_SHIFT;
        end
        T_SHIFT: begin
          cnt <= (cnt == LAST_L) ? '0 : cnt + 1'b1;
          if (bits != NBIT_L) begin
            if (cnt == HALF_L) begin
              sclk <= 1'b0;
              mosi <= shreg[FRAME_W-1];
            end
            if (cnt == LAST_L) begin
              sclk  <= 1'b1;
              shreg <= shreg << 1;
              bits  <= bits + 1'b1;
            end
          end else if (cnt == HALF_L) begin
            ss  <= 1'b0;
            gap <= '0;
            st  <= T_GAP;
          end
        end
        default: begin
          gap <= gap + 1'b1;
          if (gap == GAP_L) st <= T_IDLE;
        end
      endcase
    end
  end

  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ss |-> sclk);
  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ss && $rose(sclk)) |-> $stable(mosi));
  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !ss);

endmodule

// File: rtl/panel_seq.sv
module panel_seq
  import panel_cfg_pkg::*;
#(
  parameter int         FRAME_W      = 32,
  parameter logic [5:0] DEF_CONTRAST = 6'd47
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_op,
  input  logic [5:0]         req_arg,
  output logic               busy,
  output logic               supply_en,
  output logic               panel_en,
  output logic               tx_start,
  output logic [FRAME_W-1:0] tx_frame,
  input  logic               tx_ready,
  input  logic               tx_done,
  input  logic               tx_ss
);
  localparam logic [4:0] LAST_IDX = 5'(INIT_LEN - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SUP, S_PAN, S_IF, S_LOAD, S_WAIT, S_IFOFF, S_PANOFF, S_SUPOFF
  } sst_e;
  typedef enum logic [1:0] {M_ONE, M_PUP, M_PDN, M_INIT} mode_e;

  sst_e       st;
  mode_e      mode;
  logic [7:0] cmd_addr, cmd_val;
  logic [4:0] idx;
  logic       disp_on, intf_en;
  logic       accept;
  logic [15:0] ent;

  assign busy      = (st != S_IDLE);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign tx_start  = (st == S_LOAD) && tx_ready && intf_en;
  assign ent       = init_entry(idx, DEF_CONTRAST);
  assign tx_frame  = (mode == M_INIT) ? make_frame(ent[15:8], ent[7:0])
                                      : make_frame(cmd_addr, cmd_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      mode      <= M_ONE;
      cmd_addr  <= '0;
      cmd_val   <= '0;
      idx       <= '0;
      disp_on   <= 1'b0;
      intf_en   <= 1'b0;
      supply_en <= 1'b0;
      panel_en  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          case (req_op)
            OP_PWR_UP: begin
              mode <= M_PUP; cmd_addr <= REG_DISPLAY; cmd_val <= 8'h01;
              st <= S_SUP;
            end
            OP_INIT: begin
              mode <= M_INIT; idx <= '0; st <= S_SUP;
            end
            OP_PWR_DN: if (disp_on) begin
              mode <= M_PDN; cmd_addr <= REG_DISPLAY; cmd_val <= 8'h00;
              st <= S_LOAD;
            end
            OP_CONTRAST: if (disp_on) begin
              mode <= M_ONE; cmd_addr <= REG_CONTRAST; cmd_val <= {2'b00, req_arg};
              st <= S_LOAD;
            end
            OP_INVERT: if (disp_on) begin
              mode <= M_ONE; cmd_addr <= REG_INVERT;
              cmd_val <= req_arg[0] ? 8'h10 : 8'h00;
              st <= S_LOAD;
            end
            OP_FLIP: if (disp_on) begin
              mode <= M_ONE; cmd_addr <= REG_ORIENT;
              cmd_val <= req_arg[0] ? 8'h02 : 8'h04;
              st <= S_LOAD;
            end
            default: ;
          endcase
        end
        S_SUP:  begin supply_en <= 1'b1; st <= S_PAN; end
        S_PAN:  begin panel_en  <= 1'b1; st <= S_IF;  end
        S_IF:   begin intf_en   <= 1'b1; st <= S_LOAD; end
        S_LOAD: if (tx_start) st <= S_WAIT;
        S_WAIT: if (tx_done) begin
          if (mode == M_INIT && idx != LAST_IDX) begin
            idx <= idx + 5'd1;
            st  <= S_LOAD;
          end else if (mode == M_PDN) begin
            st <= S_IFOFF;
          end else begin
            disp_on <= 1'b1;
            st      <= S_IDLE;
          end
        end
        S_IFOFF:  begin intf_en  <= 1'b0; st <= S_PANOFF; end
        S_PANOFF: begin panel_en <= 1'b0; st <= S_SUPOFF; end
        default: begin
          supply_en <= 1'b0;
          disp_on   <= 1'b0;
          st        <= S_IDLE;
        end
      endcase
    end
  end

  p_panel_supply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    panel_en |-> supply_en);
  p_frame_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ss |-> (busy && supply_en && panel_en));
  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !disp_on && (req_op == OP_CONTRAST || req_op == OP_INVERT ||
     req_op == OP_FLIP)) |=> !busy);

endmodule

// File: rtl/panel_cfg_ctrl.sv
module panel_cfg_ctrl #(
  parameter int         DIV          = 16,
  parameter int         GAP_SCLKS    = 2,
  parameter logic [5:0] DEF_CONTRAST = 6'd47
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [2:0] req_op,
  input  logic [5:0] req_arg,
  output logic       busy,
  output logic       spi_sclk,
  output logic       spi_mosi,
  output logic       spi_ss,
  output logic       supply_en,
  output logic       panel_en
);
  localparam int FRAME_W = 32;

  logic               tx_start, tx_ready, tx_done;
  logic [FRAME_W-1:0] tx_frame;

  panel_seq #(.FRAME_W(FRAME_W), .DEF_CONTRAST(DEF_CONTRAST)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_arg(req_arg), .busy(busy),
    .supply_en(supply_en), .panel_en(panel_en),
    .tx_start(tx_start), .tx_frame(tx_frame),
    .tx_ready(tx_ready), .tx_done(tx_done), .tx_ss(spi_ss)
  );

  panel_spi_tx #(.DIV(DIV), .FRAME_W(FRAME_W), .GAP_SCLKS(GAP_SCLKS)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .start(tx_start), .frame(tx_frame),
    .tx_ready(tx_ready), .tx_done(tx_done),
    .sclk(spi_sclk), .mosi(spi_mosi), .ss(spi_ss)
  );

endmodule

// File: tb/panel_cfg_ctrl_test.sv
module panel_cfg_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [5:0] req_arg = '0;
  logic       req_ready, busy, spi_sclk, spi_mosi, spi_ss, supply_en, panel_en;

  int checks = 0;
  int failures = 0;
  int frames_seen = 0;
  int gap_bad = 0, sclk_bad = 0, order_bad = 0, edge_bad = 0;
  logic [31:0] exp_q[$];
  logic [31:0] rx_word;
  int          rx_bits;
  bit          done_flag = 0;

  always #4 clk = ~clk;

  panel_cfg_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_arg(req_arg), .busy(busy),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_ss(spi_ss),
    .supply_en(supply_en), .panel_en(panel_en)
  );

  task automatic check(input bit ok, input string req, input longint act,
                       input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Monitor: assemble frames on the sampling edge, compare at select fall.
  always @(posedge spi_sclk) if (spi_ss) begin
    rx_word = {rx_word[30:0], spi_mosi};
    rx_bits++;
  end
  always @(posedge spi_ss) begin
    rx_word = '0;
    rx_bits = 0;
  end
  always @(negedge spi_ss) if (rst_n) begin
    frames_seen++;
    if (rx_bits != 32) edge_bad++;
    if (!(supply_en && panel_en)) order_bad++;
    if (exp_q.size() == 0)
      check(0, "R1 unexpected frame", rx_word, 0);
    else begin
      logic [31:0] e;
      e = exp_q.pop_front();
      check(rx_word == e, "R1 frame content", rx_word, e);
    end
  end

  // Timing monitors, sampled away from the active edge.
  int  low_run = 1000, sclk_low_run = 0;
  logic prev_ss = 0, prev_sclk = 1;
  always @(negedge clk) if (rst_n) begin
    if (spi_ss && !prev_ss && low_run < 32) gap_bad++;
    low_run = spi_ss ? 0 : low_run + 1;
    if (!spi_ss && !spi_sclk) sclk_bad++;
    if (panel_en && !supply_en) order_bad++;
    if (spi_sclk && !prev_sclk && sclk_low_run != 8) sclk_bad++;
    sclk_low_run = spi_sclk ? 0 : sclk_low_run + 1;
    prev_ss = spi_ss;
    prev_sclk = spi_sclk;
  end

  // Driver: hold valid until the design accepts.
  task automatic send(input logic [2:0] op, input logic [5:0] arg);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_arg = arg;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  function automatic logic [31:0] fr(input logic [7:0] a, input logic [7:0] v);
    return {8'h00, a, 8'h01, v};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n0;
    logic [15:0] init_list[25];
    init_list = '{16'h0f01, 16'h0906, 16'h16a6, 16'h1e49, 16'h1f26, 16'h0b2f,
                  16'h0c2b, 16'h195e, 16'h1a15, 16'h1b15, 16'h1d01, 16'h0003,
                  16'h0110, 16'h020a, 16'h0604, 16'h082e, 16'h2412, 16'h253f,
                  16'h260b, 16'h2700, 16'h2800, 16'h29f6, 16'h2a03, 16'h2b0a,
                  16'h0401};
    repeat (3) @(negedge clk);
    check(!busy && req_ready && !spi_ss && spi_sclk && !supply_en && !panel_en,
          "R11 reset state", {busy, req_ready, spi_ss, spi_sclk, supply_en, panel_en},
          6'b010100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9: mode requests while off are dropped; R8: power down while off ignored.
    n0 = frames_seen;
    send(3'd2, 6'd9);
    check(!busy, "R9 contrast dropped busy", busy, 0);
    send(3'd3, 6'd1);
    send(3'd4, 6'd1);
    send(3'd1, 6'd0);
    check(!busy, "R8 power down while off", busy, 0);
    send(3'd7, 6'd0);
    check(!busy, "R11 unused op ignored", busy, 0);
    repeat (700) @(negedge clk);
    check(frames_seen == n0 && !supply_en, "R9 no frame while off", frames_seen - n0, 0);

    // R7: power-up pin order, then display-on frame.
    exp_q.push_back(fr(8'h04, 8'h01));
    send(3'd0, 6'd0);
    check(busy && !supply_en && !panel_en, "R7 step0", {supply_en, panel_en}, 0);
    @(negedge clk);
    check(supply_en && !panel_en, "R7 supply first", {supply_en, panel_en}, 2'b10);
    @(negedge clk);
    check(supply_en && panel_en && !spi_ss, "R7 panel second", {supply_en, panel_en}, 2'b11);
    repeat (100) @(negedge clk);
    check(spi_ss && busy && !req_ready, "R11 busy during frame", {spi_ss, busy, req_ready}, 3'b110);

    // R4, R6, R5: queued back to back while busy (request meets frame end).
    exp_q.push_back(fr(8'h0B, 8'h05));
    send(3'd2, 6'd5);
    exp_q.push_back(fr(8'h0B, 8'h3F));
    send(3'd2, 6'd63);
    exp_q.push_back(fr(8'h0B, 8'h00));
    send(3'd2, 6'd0);
    exp_q.push_back(fr(8'h27, 8'h10));
    send(3'd3, 6'd1);
    exp_q.push_back(fr(8'h27, 8'h00));
    send(3'd3, 6'd0);
    exp_q.push_back(fr(8'h06, 8'h02));
    send(3'd4, 6'd1);
    exp_q.push_back(fr(8'h06, 8'h04));
    send(3'd4, 6'd0);
    wait_idle();
    check(!spi_ss && req_ready, "R11 idle after last frame", spi_ss, 0);

    // R8: power down.
    exp_q.push_back(fr(8'h04, 8'h00));
    send(3'd1, 6'd0);
    wait_idle();
    check(!supply_en && !panel_en, "R8 pins low after power down",
          {supply_en, panel_en}, 0);
    n0 = frames_seen;
    send(3'd4, 6'd1);
    repeat (700) @(negedge clk);
    check(frames_seen == n0 && !busy, "R9 flip dropped after power down",
          frames_seen - n0, 0);

    // R10: init sequence from the off state.
    foreach (init_list[i]) exp_q.push_back(fr(init_list[i][15:8], init_list[i][7:0]));
    n0 = frames_seen;
    send(3'd5, 6'd0);
    wait_idle();
    check(frames_seen - n0 == 25, "R10 init frame count", frames_seen - n0, 25);
    check(supply_en && panel_en, "R10 powered after init", {supply_en, panel_en}, 2'b11);
    exp_q.push_back(fr(8'h0B, 8'h2A));
    send(3'd2, 6'd42);
    wait_idle();
    check(frames_seen - n0 == 26, "R10 display on after init", frames_seen - n0, 26);

    repeat (50) @(negedge clk);
    check(exp_q.size() == 0, "R1 all expected frames seen", exp_q.size(), 0);
    check(gap_bad == 0, "R2 select gap", gap_bad, 0);
    check(sclk_bad == 0, "R3 clock idle and period", sclk_bad, 0);
    check(edge_bad == 0, "R3 32 edges per frame", edge_bad, 0);
    check(order_bad == 0, "R8 panel never without supply", order_bad, 0);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule